// File: doc/BRIEF.md
# Shared-Adder Arithmetic Logic Unit

This block is a purely combinational arithmetic logic unit for operands of a configurable width (four bits unless set otherwise). Two operands and a three-bit operation code enter; a result word and four status flags (zero, carry, negative, signed overflow) leave. Nothing is clocked and nothing is stored: every output is a function of the present inputs only, so any operand or flag holding belongs to the surrounding datapath.

Addition and subtraction share one ripple chain of full-adder cells. A single subtract control inverts every bit of the second operand and also feeds the chain's carry-in, which turns A + B into A + ~B + 1 = A − B. The bitwise operations are evaluated side by side with the arithmetic path, and a selector forwards exactly one of the candidate results. The carry flag is the carry out of the top stage; after a subtraction it therefore reads 1 when no borrow occurred.

Top module: `sa_alu`

## Requirements
- R1: Code 3'b000 (add) gives F = (A + B) mod 2^W and C = the carry out of the most significant stage.
- R2: Code 3'b001 (subtract) gives F = (A − B) mod 2^W and C = 1 exactly when A >= B as unsigned numbers (no borrow); borrow is the inverse of C.
- R3: For add and subtract, V is 1 exactly when the true two's-complement result lies outside the signed W-bit range, i.e. the carry into the sign stage differs from the carry out of it.
- R4: Codes 3'b010, 3'b011 and 3'b100 give the bitwise AND, OR and XOR of A and B.
- R5: Code 3'b101 gives F = ~A; the value of B has no effect on any output.
- R6: Codes 3'b110 and 3'b111 give F = 0 regardless of A and B.
- R7: Z is 1 exactly when every bit of F is 0, for every code.
- R8: N equals bit W−1 of F, for every code.
- R9: For every code other than add and subtract, C and V are 0.
- R10: The outputs follow a change of any input with no clock edge involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | WIDTH | First operand A |
| opb_i | input | WIDTH | Second operand B |
| op_sel_i | input | 3 | Operation code |
| res_o | output | WIDTH | Selected result F |
| flag_z_o | output | 1 | Result is all zeros |
| flag_c_o | output | 1 | Carry out of top stage (arithmetic only) |
| flag_n_o | output | 1 | Top bit of the result |
| flag_v_o | output | 1 | Signed overflow (arithmetic only) |

## Verification
A hand-written table covers the sign-boundary cases that separate carry from overflow: adding into the sign bit, wrapping −1 + 1, two most-negative values summed, subtracting below the most-negative value and equal operands yielding zero with no borrow. An exhaustive sweep of all operand pairs under all eight codes then compares result and flags with a wider-integer reference, which distinguishes a wrong carry-in, a missing inversion, swapped codes and flags leaking out of the logic operations. A final directed step changes the inputs between clock edges to show that the outputs respond without one.

// File: rtl/sa_alu_pkg.sv
package sa_alu_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'b000,
        OP_SUB  = 3'b001,
        OP_AND  = 3'b010,
        OP_OR   = 3'b011,
        OP_XOR  = 3'b100,
        OP_NOTA = 3'b101,
        OP_RSV6 = 3'b110,
        OP_RSV7 = 3'b111
    } op_e;

    typedef struct packed {
        logic z;
        logic c;
        logic n;
        logic v;
    } flags_t;

    // Signed overflow from the carries around the sign stage.
    function automatic logic sign_ovf(input logic carry_out, input logic carry_in_msb);
        return carry_out ^ carry_in_msb;
    endfunction

    function automatic logic is_arith(input op_e op);
        return (op == OP_ADD) || (op == OP_SUB);
    endfunction

endpackage

// File: rtl/sa_fa_cell.sv
module sa_fa_cell (
    input  logic a_i,
    input  logic b_i,
    input  logic c_i,
    output logic s_o,
    output logic c_o
);
    logic half;

    always_comb begin
        half = a_i ^ b_i;
        s_o  = half ^ c_i;
        c_o  = (a_i & b_i) | (c_i & half);
    end
endmodule

// File: rtl/sa_addsub_chain.sv
module sa_addsub_chain #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             sub_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o,
    output logic             cin_msb_o
);
    logic [WIDTH-1:0] b_eff;
    logic [WIDTH:0]   carry;

    assign b_eff    = b_i ^ {WIDTH{sub_i}};
    assign carry[0] = sub_i;

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        sa_fa_cell u_cell (
            .a_i (a_i[i]),
            .b_i (b_eff[i]),
            .c_i (carry[i]),
            .s_o (sum_o[i]),
            .c_o (carry[i+1])
        );
    end

    assign cout_o    = carry[WIDTH];
    assign cin_msb_o = carry[WIDTH-1];
endmodule

// File: rtl/sa_bitwise_unit.sv
module sa_bitwise_unit #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] and_o,
    output logic [WIDTH-1:0] or_o,
    output logic [WIDTH-1:0] xor_o,
    output logic [WIDTH-1:0] nota_o
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign and_o[i]  = a_i[i] & b_i[i];
        assign or_o[i]   = a_i[i] | b_i[i];
        assign xor_o[i]  = a_i[i] ^ b_i[i];
        assign nota_o[i] = ~a_i[i];
    end
endmodule

// File: rtl/sa_result_sel.sv
module sa_result_sel
    import sa_alu_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  op_e              op_i,
    input  logic [WIDTH-1:0] sum_i,
    input  logic             cout_i,
    input  logic             cin_msb_i,
    input  logic [WIDTH-1:0] and_i,
    input  logic [WIDTH-1:0] or_i,
    input  logic [WIDTH-1:0] xor_i,
    input  logic [WIDTH-1:0] nota_i,
    output logic [WIDTH-1:0] res_o,
    output flags_t           flags_o
);
    localparam int MSB = WIDTH - 1;

    always_comb begin
        unique case (op_i)
            OP_ADD, OP_SUB: res_o = sum_i;
            OP_AND:         res_o = and_i;
            OP_OR:          res_o = or_i;
            OP_XOR:         res_o = xor_i;
            OP_NOTA:        res_o = nota_i;
            default:        res_o = '0;
        endcase
    end

    always_comb begin
        flags_o.z = ~(|res_o);
        flags_o.n = res_o[MSB];
        flags_o.c = is_arith(op_i) ? cout_i : 1'b0;
        flags_o.v = is_arith(op_i) ? sign_ovf(cout_i, cin_msb_i) : 1'b0;
    end
endmodule

// File: rtl/sa_alu.sv
module sa_alu
    import sa_alu_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] opa_i,
    input  logic [WIDTH-1:0] opb_i,
    input  logic [2:0]       op_sel_i,
    output logic [WIDTH-1:0] res_o,
    output logic             flag_z_o,
    output logic             flag_c_o,
    output logic             flag_n_o,
    output logic             flag_v_o
);
    op_e              op;
    logic             sub_en;
    logic [WIDTH-1:0] sum, and_v, or_v, xor_v, nota_v;
    logic             cout, cin_msb;
    flags_t           flags;

    assign op     = op_e'(op_sel_i);
    assign sub_en = (op == OP_SUB);

    sa_addsub_chain #(.WIDTH(WIDTH)) u_chain (
        .a_i       (opa_i),
        .b_i       (opb_i),
        .sub_i     (sub_en),
        .sum_o     (sum),
        .cout_o    (cout),
        .cin_msb_o (cin_msb)
    );

    sa_bitwise_unit #(.WIDTH(WIDTH)) u_bitwise (
        .a_i    (opa_i),
        .b_i    (opb_i),
        .and_o  (and_v),
        .or_o   (or_v),
        .xor_o  (xor_v),
        .nota_o (nota_v)
    );

    sa_result_sel #(.WIDTH(WIDTH)) u_sel (
        .op_i      (op),
        .sum_i     (sum),
        .cout_i    (cout),
        .cin_msb_i (cin_msb),
        .and_i     (and_v),
        .or_i      (or_v),
        .xor_i     (xor_v),
        .nota_i    (nota_v),
        .res_o     (res_o),
        .flags_o   (flags)
    );

    assign flag_z_o = flags.z;
    assign flag_c_o = flags.c;
    assign flag_n_o = flags.n;
    assign flag_v_o = flags.v;
endmodule

// File: rtl/sa_alu_chk.sv
module sa_alu_chk #(
    parameter int WIDTH = 4
) (
    input logic [WIDTH-1:0] opa_i,
    input logic [WIDTH-1:0] opb_i,
    input logic [2:0]       op_sel_i,
    input logic [WIDTH-1:0] res_o,
    input logic             flag_z_o,
    input logic             flag_c_o,
    input logic             flag_n_o,
    input logic             flag_v_o
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH:0] add_ref, sub_ref;
    logic           known;

    always_comb begin
        add_ref = {1'b0, opa_i} + {1'b0, opb_i};
        sub_ref = {1'b0, opa_i} + {1'b0, ~opb_i} + 1'b1;
        known   = !$isunknown({opa_i, opb_i, op_sel_i, res_o,
                               flag_z_o, flag_c_o, flag_n_o, flag_v_o});
    end

    always_comb begin
        if (known) begin
            // R1
            add_sum_chk: assert (op_sel_i != 3'b000 || {flag_c_o, res_o} == add_ref)
                else $error("add result/carry wrong");
            // R2
            sub_diff_chk: assert (op_sel_i != 3'b001 || {flag_c_o, res_o} == sub_ref)
                else $error("subtract result/carry wrong");
            // R3
            add_ovf_chk: assert (op_sel_i != 3'b000 ||
                flag_v_o == ((opa_i[MSB] == opb_i[MSB]) && (res_o[MSB] != opa_i[MSB])))
                else $error("add overflow wrong");
            // R3
            sub_ovf_chk: assert (op_sel_i != 3'b001 ||
                flag_v_o == ((opa_i[MSB] != opb_i[MSB]) && (res_o[MSB] != opa_i[MSB])))
                else $error("subtract overflow wrong");
            // R5
            nota_res_chk: assert (op_sel_i != 3'b101 || res_o == ~opa_i)
                else $error("not-A result wrong");
            // R6
            rsv_zero_chk: assert (op_sel_i[2:1] != 2'b11 || res_o == '0)
                else $error("reserved code result not zero");
            // R7
            zero_flag_chk: assert (flag_z_o == (res_o == '0))
                else $error("zero flag wrong");
            // R8
            neg_flag_chk: assert (flag_n_o == res_o[MSB])
                else $error("negative flag wrong");
            // R9
            logic_cv_chk: assert (op_sel_i[2:1] == 2'b00 || (!flag_c_o && !flag_v_o))
                else $error("carry/overflow set on non-arithmetic code");
        end
    end
endmodule

bind sa_alu sa_alu_chk #(.WIDTH(WIDTH)) u_sa_alu_chk (
    .opa_i    (opa_i),
    .opb_i    (opb_i),
    .op_sel_i (op_sel_i),
    .res_o    (res_o),
    .flag_z_o (flag_z_o),
    .flag_c_o (flag_c_o),
    .flag_n_o (flag_n_o),
    .flag_v_o (flag_v_o)
);

// File: tb/sa_alu_bench.sv
module sa_alu_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 4;
    localparam int NVEC       = 15;

    // entry: op[18:16] a[15:12] b[11:8] f[7:4] z c n v [3:0]
    localparam logic [18:0] VEC [NVEC] = '{
        {3'b000, 4'h3, 4'h4, 4'h7, 4'b0000},
        {3'b000, 4'h7, 4'h1, 4'h8, 4'b0011},
        {3'b000, 4'hF, 4'h1, 4'h0, 4'b1100},
        {3'b000, 4'h8, 4'h8, 4'h0, 4'b1101},
        {3'b001, 4'h5, 4'h3, 4'h2, 4'b0100},
        {3'b001, 4'h3, 4'h5, 4'hE, 4'b0010},
        {3'b001, 4'h8, 4'h1, 4'h7, 4'b0101},
        {3'b001, 4'h6, 4'h6, 4'h0, 4'b1100},
        {3'b010, 4'hC, 4'hA, 4'h8, 4'b0010},
        {3'b011, 4'h5, 4'hA, 4'hF, 4'b0010},
        {3'b100, 4'hF, 4'hF, 4'h0, 4'b1000},
        {3'b101, 4'h3, 4'hF, 4'hC, 4'b0010},
        {3'b101, 4'hF, 4'h0, 4'h0, 4'b1000},
        {3'b110, 4'hF, 4'hF, 4'h0, 4'b1000},
        {3'b111, 4'h7, 4'h9, 4'h0, 4'b1000}
    };

    logic         clk = 1'b0;
    logic [W-1:0] opa, opb, res;
    logic [2:0]   op_sel;
    logic         fz, fc, fn, fv;
    int           n_checks = 0;
    int           n_fail   = 0;
    bit           done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sa_alu #(.WIDTH(W)) u_sa_alu (
        .opa_i    (opa),
        .opb_i    (opb),
        .op_sel_i (op_sel),
        .res_o    (res),
        .flag_z_o (fz),
        .flag_c_o (fc),
        .flag_n_o (fn),
        .flag_v_o (fv)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d (op=%0d a=%0d b=%0d)",
                     tag, what, act, exp, op_sel, opa, opb);
        end
    endtask

    task automatic apply(input logic [2:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
        @(negedge clk);
        op_sel = op;
        opa    = a;
        opb    = b;
        #1;
    endtask

    function automatic string op_tag(input int op);
        case (op)
            0: return "R1";
            1: return "R2";
            2, 3, 4: return "R4";
            5: return "R5";
            default: return "R6";
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // all-zero inputs: add of zeros (R7)
        apply(3'b000, '0, '0);
        chk("R7", "idle res", int'(res), 0);
        chk("R7", "idle z", int'(fz), 1);
        chk("R9", "idle c/v", int'({fc, fv}), 0);

        // table of directed corner vectors
        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i][18:16], VEC[i][15:12], VEC[i][11:8]);
            chk(op_tag(int'(VEC[i][18:16])), "table res", int'(res), int'(VEC[i][7:4]));
            chk("R7", "table z", int'(fz), int'(VEC[i][3]));
            chk(VEC[i][18:17] == 2'b00 ? "R1/R2" : "R9", "table c", int'(fc), int'(VEC[i][2]));
            chk("R8", "table n", int'(fn), int'(VEC[i][1]));
            chk(VEC[i][18:17] == 2'b00 ? "R3" : "R9", "table v", int'(fv), int'(VEC[i][0]));
        end

        // exhaustive sweep against a wider-integer reference
        for (int op = 0; op < 8; op++) begin
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 16; b++) begin
                    int raw, ef, ec, ev, sa, sb, sr;
                    apply(3'(op), 4'(a), 4'(b));
                    sa = (a >= 8) ? a - 16 : a;
                    sb = (b >= 8) ? b - 16 : b;
                    ec = 0;
                    ev = 0;
                    case (op)
                        0: begin raw = a + b; ef = raw % 16; ec = raw / 16;
                                 sr = sa + sb; ev = (sr < -8 || sr > 7) ? 1 : 0; end
                        1: begin ef = (a - b + 16) % 16; ec = (a >= b) ? 1 : 0;
                                 sr = sa - sb; ev = (sr < -8 || sr > 7) ? 1 : 0; end
                        2: ef = a & b;
                        3: ef = a | b;
                        4: ef = a ^ b;
                        5: ef = 15 - a;
                        default: ef = 0;
                    endcase
                    chk(op_tag(op), "sweep res", int'(res), ef);
                    chk("R7", "sweep z", int'(fz), (ef == 0) ? 1 : 0);
                    chk("R8", "sweep n", int'(fn), (ef >= 8) ? 1 : 0);
                    chk(op < 2 ? "R1/R2" : "R9", "sweep c", int'(fc), ec);
                    chk(op < 2 ? "R3" : "R9", "sweep v", int'(fv), ev);
                end
            end
        end

        // R10: inputs changed between edges, outputs respond with no edge
        @(posedge clk);
        #1;
        op_sel = 3'b000; opa = 4'h2; opb = 4'h3;
        #1;
        chk("R10", "mid-cycle add", int'(res), 5);
        op_sel = 3'b001;
        #1;
        chk("R10", "mid-cycle sub", int'(res), 15);
        chk("R10", "mid-cycle borrow", int'(fc), 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule